// File: doc/BRIEF.md
# Fuse Map Store with Signature and Read Lock

This block is the configuration store of a small programmable logic array. It holds the functional fuse pattern, a 64-bit user signature that comes after the functional fuses in the address space, and one lock cell. A loader programs the store by issuing a program command and then streaming fuse values one bit per accepted cycle, starting at address 0. Each program command first clears the whole array, the signature and the lock. The loader chooses one of two map lengths. The long map carries the functional fuses and then the signature. The short map carries only the functional fuses and leaves the signature cleared.

The store serves reads while it is idle. A read can fetch one fuse bit by address, or one signature byte by its index. Once the lock cell is set, reads of functional fuses return zero and raise a one-cycle denial flag. Signature reads are never refused. The lock can only be removed by issuing a new program command, and that command clears the functional array at the same time.

Top module: `cfg_fuse_store`

## Requirements
- R1: After reset, busy, fuse_ready, rd_valid and rd_denied are 0, the lock is clear, and every signature byte reads 0.
- R2: A prog_start while idle raises busy on the next cycle. It then runs an erase phase of ceil(5828/32) = 183 cycles with fuse_ready low. fuse_valid is ignored during this phase. The phase zeroes every functional fuse, the signature and the lock.
- R3: In the write phase, fuse_ready is high. Each cycle with fuse_valid and fuse_ready stores fuse_bit at the next address, counting up from 0. Cycles without fuse_valid store nothing.
- R4: prog_full=1 selects the long map of 5892 bits, where addresses 5828..5891 are signature bits 0..63. prog_full=0 selects the short map of 5828 bits. busy and fuse_ready are low on the cycle after the last bit is accepted.
- R5: After a short map, all 64 signature bits read 0, even if a previous program had set them.
- R6: An idle read with rd_sig=0 of an address below 5828 gives, on the next cycle, rd_valid=1 with the stored fuse in rd_data[0] and zeros in rd_data[7:1].
- R7: If prog_lock=1 was sampled with prog_start, functional reads after completion return rd_data=0 with rd_denied=1 for that single cycle.
- R8: Signature reads are never denied, whatever the lock state. These are bit reads at addresses 5828..5891 and byte reads with rd_sig=1.
- R9: A byte read with rd_sig=1 uses rd_addr[2:0] as the byte index k. Bit j of rd_data is the fuse at address 5828+8k+j, so byte 0 holds the lowest addresses.
- R10: A prog_start while busy is ignored. An rd_req while busy gives no rd_valid. The lock is cleared only by an accepted prog_start.
- R11: A bit read at an address of 5892 or above returns 0 with rd_valid=1 and rd_denied=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_start | input | 1 | Start a program command (taken only when idle) |
| prog_full | input | 1 | Map length select: 1 long (with signature), 0 short |
| prog_lock | input | 1 | Set the lock cell at the end of this program |
| fuse_valid | input | 1 | Fuse bit present on fuse_bit |
| fuse_bit | input | 1 | Fuse value for the next address |
| fuse_ready | output | 1 | Write phase: fuse bits are accepted |
| busy | output | 1 | Erase or write phase in progress |
| rd_req | input | 1 | Read request (served when idle) |
| rd_sig | input | 1 | 1: signature byte read, 0: fuse bit read |
| rd_addr | input | 13 | Fuse address, or byte index in bits [2:0] |
| rd_valid | output | 1 | Read result present |
| rd_data | output | 8 | Read result |
| rd_denied | output | 1 | Functional read refused by the lock |

## Verification
The bench drives fuse_valid with junk during the erase phase. A design that took those bits would corrupt the first fuses. The bench also counts the erase cycles, which exposes an off-by-one in the word sweep. It loads a long map and then a short map, so a design that failed to clear the signature would leave the old bytes readable. It checks signature bytes bit by bit, which catches byte or bit order reversal. Under the lock, it checks that functional reads return zero and are flagged, while signature reads still return data. A design that gated every read would fail there. A design that never released the lock would fail after the final unlocked program. A stray prog_start in mid-stream would restart the erase in a design that did not guard it, and the fuse contents would no longer match.

// File: rtl/cfgm_pkg.sv
package cfgm_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_ERASE, PH_WRITE} phase_e;
  typedef enum logic [1:0] {RG_FUNC, RG_SIG, RG_NONE} region_e;

  function automatic int unsigned ceil_div(int unsigned n, int unsigned d);
    return (n + d - 1) / d;
  endfunction

  function automatic region_e classify(int unsigned a, int unsigned func_bits,
                                       int unsigned sig_bits);
    if (a < func_bits) return RG_FUNC;
    if (a < func_bits + sig_bits) return RG_SIG;
    return RG_NONE;
  endfunction
endpackage

// File: rtl/cfgm_sequencer.sv
module cfgm_sequencer import cfgm_pkg::*; #(
  parameter int FUNC_BITS = 5828,
  parameter int SIG_BITS  = 64,
  parameter int WORD_W    = 32,
  parameter int AW        = 13,
  parameter int EW_AW     = 8,
  parameter int SW        = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prog_start,
  input  logic             prog_full,
  input  logic             prog_lock,
  input  logic             fuse_valid,
  input  logic             fuse_bit,
  output logic             busy,
  output logic             fuse_ready,
  output logic             erase_en,
  output logic [EW_AW-1:0] erase_idx,
  output logic             fw_en,
  output logic [AW-1:0]    fw_addr,
  output logic             fw_bit,
  output logic             sw_en,
  output logic [SW-1:0]    sw_idx,
  output logic             sw_bit,
  output logic             start_ok,
  output logic             sec_set,
  output logic             done_evt
);
  localparam int TOTAL  = FUNC_BITS + SIG_BITS;
  localparam int EWORDS = ceil_div(FUNC_BITS, WORD_W);
  localparam logic [AW-1:0]    FUNC_A  = AW'(FUNC_BITS);
  localparam logic [AW-1:0]    LAST_L  = AW'(TOTAL - 1);
  localparam logic [AW-1:0]    LAST_S  = AW'(FUNC_BITS - 1);
  localparam logic [EW_AW-1:0] ELAST   = EW_AW'(EWORDS - 1);

  phase_e            phase_q;
  logic [EW_AW-1:0]  eidx_q;
  logic [AW-1:0]     cnt_q;
  logic              full_q, lock_q;
  logic              take;
  logic [AW-1:0]     last_cnt;

  assign last_cnt = full_q ? LAST_L : LAST_S;
  assign start_ok = (phase_q == PH_IDLE) && prog_start;
  assign take     = (phase_q == PH_WRITE) && fuse_valid;
  assign done_evt = take && (cnt_q == last_cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      eidx_q  <= '0;
      cnt_q   <= '0;
      full_q  <= 1'b0;
      lock_q  <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (prog_start) begin
          phase_q <= PH_ERASE;
          eidx_q  <= '0;
          cnt_q   <= '0;
          full_q  <= prog_full;
          lock_q  <= prog_lock;
        end
        PH_ERASE: begin
          eidx_q <= eidx_q + 1'b1;
          if (eidx_q == ELAST) phase_q <= PH_WRITE;
        end
        PH_WRITE: if (fuse_valid) begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == last_cnt) phase_q <= PH_IDLE;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign busy       = (phase_q != PH_IDLE);
  assign fuse_ready = (phase_q == PH_WRITE);
  assign erase_en   = (phase_q == PH_ERASE);
  assign erase_idx  = eidx_q;
  assign fw_en      = take && (cnt_q < FUNC_A);
  assign fw_addr    = cnt_q;
  assign fw_bit     = fuse_bit;
  assign sw_en      = take && (cnt_q >= FUNC_A);
  assign sw_idx     = SW'(cnt_q - FUNC_A);
  assign sw_bit     = fuse_bit;
  assign sec_set    = done_evt && lock_q;
endmodule

// File: rtl/cfgm_fuse_array.sv
module cfgm_fuse_array import cfgm_pkg::*; #(
  parameter int FUNC_BITS = 5828,
  parameter int WORD_W    = 32,
  parameter int AW        = 13,
  parameter int EW_AW     = 8
) (
  input  logic             clk,
  input  logic             erase_en,
  input  logic [EW_AW-1:0] erase_idx,
  input  logic             fw_en,
  input  logic [AW-1:0]    fw_addr,
  input  logic             fw_bit,
  input  logic [AW-1:0]    rd_addr,
  output logic             rd_bit
);
  localparam int EWORDS = ceil_div(FUNC_BITS, WORD_W);
  localparam int OFF_W  = $clog2(WORD_W);
  localparam int WI_W   = AW - OFF_W;

  logic [WORD_W-1:0] mem_q [EWORDS];
  logic [WI_W-1:0]   w_word, r_word;
  logic [OFF_W-1:0]  w_off, r_off;

  assign w_word = fw_addr[AW-1:OFF_W];
  assign w_off  = fw_addr[OFF_W-1:0];
  assign r_word = rd_addr[AW-1:OFF_W];
  assign r_off  = rd_addr[OFF_W-1:0];

  always_ff @(posedge clk) begin
    if (erase_en) mem_q[erase_idx] <= '0;
    else if (fw_en) mem_q[w_word][w_off] <= fw_bit;
  end

  assign rd_bit = (int'(r_word) < EWORDS) ? mem_q[r_word][r_off] : 1'b0;
endmodule

// File: rtl/cfgm_sig_lock.sv
module cfgm_sig_lock #(
  parameter int SIG_BITS = 64,
  parameter int SW       = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                sw_en,
  input  logic [SW-1:0]       sw_idx,
  input  logic                sw_bit,
  input  logic                sec_set,
  output logic [SIG_BITS-1:0] sig,
  output logic                secure
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      sig    <= '0;
      secure <= 1'b0;
    end else begin
      if (sw_en) sig[sw_idx] <= sw_bit;
      if (sec_set) secure <= 1'b1;
    end
  end
endmodule

// File: rtl/cfgm_read_port.sv
module cfgm_read_port import cfgm_pkg::*; #(
  parameter int FUNC_BITS = 5828,
  parameter int SIG_BITS  = 64,
  parameter int AW        = 13,
  parameter int SW        = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_req,
  input  logic                rd_sig,
  input  logic [AW-1:0]       rd_addr,
  input  logic                busy,
  input  logic                secure,
  input  logic                func_bit,
  input  logic [SIG_BITS-1:0] sig,
  output logic                rd_valid,
  output logic [7:0]          rd_data,
  output logic                rd_denied
);
  localparam int BI_W = $clog2(SIG_BITS / 8);

  region_e          reg_c;
  logic [SW-1:0]    sbit_c;
  logic [BI_W-1:0]  sbyte_c;
  logic             serve;
  logic [7:0]       data_c;
  logic             deny_c;

  assign serve   = rd_req && !busy;
  assign reg_c   = classify(32'(rd_addr), FUNC_BITS, SIG_BITS);
  assign sbit_c  = SW'(rd_addr - AW'(FUNC_BITS));
  assign sbyte_c = rd_addr[BI_W-1:0];

  always_comb begin
    data_c = '0;
    deny_c = 1'b0;
    if (rd_sig) begin
      data_c = sig[{sbyte_c, 3'b000} +: 8];
    end else begin
      unique case (reg_c)
        RG_FUNC: if (secure) deny_c = 1'b1;
                 else data_c[0] = func_bit;
        RG_SIG:  data_c[0] = sig[sbit_c];
        default: data_c = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid  <= 1'b0;
      rd_data   <= '0;
      rd_denied <= 1'b0;
    end else begin
      rd_valid  <= serve;
      rd_data   <= serve ? data_c : 8'h00;
      rd_denied <= serve && deny_c;
    end
  end
endmodule

// File: rtl/cfg_fuse_store.sv
module cfg_fuse_store import cfgm_pkg::*; #(
  parameter int FUNC_BITS = 5828,
  parameter int SIG_BITS  = 64,
  parameter int WORD_W    = 32,
  localparam int ADDR_W   = $clog2(FUNC_BITS + SIG_BITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_start,
  input  logic              prog_full,
  input  logic              prog_lock,
  input  logic              fuse_valid,
  input  logic              fuse_bit,
  output logic              fuse_ready,
  output logic              busy,
  input  logic              rd_req,
  input  logic              rd_sig,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  output logic              rd_denied
);
  localparam int EWORDS = ceil_div(FUNC_BITS, WORD_W);
  localparam int EW_AW  = (EWORDS > 1) ? $clog2(EWORDS) : 1;
  localparam int SW     = $clog2(SIG_BITS);

  logic                erase_en, fw_en, fw_bit, sw_en, sw_bit;
  logic [EW_AW-1:0]    erase_idx;
  logic [ADDR_W-1:0]   fw_addr;
  logic [SW-1:0]       sw_idx;
  logic                start_ok, sec_set, done_evt;
  logic [SIG_BITS-1:0] sig_q;
  logic                secure_q, func_bit;

  cfgm_sequencer #(.FUNC_BITS(FUNC_BITS), .SIG_BITS(SIG_BITS), .WORD_W(WORD_W),
                   .AW(ADDR_W), .EW_AW(EW_AW), .SW(SW)) u_seq (
    .clk(clk), .rst_n(rst_n), .prog_start(prog_start), .prog_full(prog_full),
    .prog_lock(prog_lock), .fuse_valid(fuse_valid), .fuse_bit(fuse_bit),
    .busy(busy), .fuse_ready(fuse_ready), .erase_en(erase_en),
    .erase_idx(erase_idx), .fw_en(fw_en), .fw_addr(fw_addr), .fw_bit(fw_bit),
    .sw_en(sw_en), .sw_idx(sw_idx), .sw_bit(sw_bit), .start_ok(start_ok),
    .sec_set(sec_set), .done_evt(done_evt));

  cfgm_fuse_array #(.FUNC_BITS(FUNC_BITS), .WORD_W(WORD_W), .AW(ADDR_W),
                    .EW_AW(EW_AW)) u_arr (
    .clk(clk), .erase_en(erase_en), .erase_idx(erase_idx), .fw_en(fw_en),
    .fw_addr(fw_addr), .fw_bit(fw_bit), .rd_addr(rd_addr), .rd_bit(func_bit));

  cfgm_sig_lock #(.SIG_BITS(SIG_BITS), .SW(SW)) u_sig (
    .clk(clk), .rst_n(rst_n), .clr(start_ok), .sw_en(sw_en), .sw_idx(sw_idx),
    .sw_bit(sw_bit), .sec_set(sec_set), .sig(sig_q), .secure(secure_q));

  cfgm_read_port #(.FUNC_BITS(FUNC_BITS), .SIG_BITS(SIG_BITS), .AW(ADDR_W),
                   .SW(SW)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_sig(rd_sig),
    .rd_addr(rd_addr), .busy(busy), .secure(secure_q), .func_bit(func_bit),
    .sig(sig_q), .rd_valid(rd_valid), .rd_data(rd_data), .rd_denied(rd_denied));
endmodule

// File: rtl/cfg_fuse_store_chk.sv
module cfg_fuse_store_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       prog_start,
  input logic       busy,
  input logic       fuse_ready,
  input logic       erase_en,
  input logic       rd_req,
  input logic       rd_sig,
  input logic       rd_valid,
  input logic [7:0] rd_data,
  input logic       rd_denied,
  input logic       secure,
  input logic       done_evt
);
  // R2: busy only rises in response to a program command
  a_r2_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(prog_start));
  // R2: fuse bits are never taken while the array is being cleared
  a_r2_erase_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    erase_en |-> !fuse_ready);
  // R4: the store goes idle right after the last accepted bit
  a_r4_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> !busy && !fuse_ready);
  // R6 and R10: a result appears only after an idle request
  a_r6_valid_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_req) && !$past(busy));
  // R7: a refused read carries no data and needs the lock
  a_r7_denied_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_denied |-> rd_valid && rd_data == 8'h00 && $past(secure));
  // R8: signature byte reads are never refused
  a_r8_sig_never_denied: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && $past(rd_sig) |-> !rd_denied);
  // R10: the lock drops only when a program command is accepted
  a_r10_lock_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(secure) |-> $past(prog_start) && !$past(busy));
endmodule

bind cfg_fuse_store cfg_fuse_store_chk u_chk (
  .clk(clk), .rst_n(rst_n), .prog_start(prog_start), .busy(busy),
  .fuse_ready(fuse_ready), .erase_en(erase_en), .rd_req(rd_req),
  .rd_sig(rd_sig), .rd_valid(rd_valid), .rd_data(rd_data),
  .rd_denied(rd_denied), .secure(secure_q), .done_evt(done_evt));

// File: tb/cfg_fuse_store_tb.sv
module cfg_fuse_store_tb;
  localparam int FB = 5828;
  localparam int SB = 64;
  localparam int EW = (FB + 31) / 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic prog_start = 0, prog_full = 0, prog_lock = 0, fuse_valid = 0, fuse_bit = 0;
  logic rd_req = 0, rd_sig = 0;
  logic [12:0] rd_addr = '0;
  logic fuse_ready, busy, rd_valid, rd_denied;
  logic [7:0] rd_data;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cfg_fuse_store u_dut (.clk(clk), .rst_n(rst_n), .prog_start(prog_start),
    .prog_full(prog_full), .prog_lock(prog_lock), .fuse_valid(fuse_valid),
    .fuse_bit(fuse_bit), .fuse_ready(fuse_ready), .busy(busy), .rd_req(rd_req),
    .rd_sig(rd_sig), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_denied(rd_denied));

  function automatic logic pat(int s, int a);
    logic [31:0] h;
    h = 32'(a) * 32'h0000_9E37 + 32'(s) * 32'h0001_7F4B;
    return h[9] ^ h[4] ^ h[14];
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_read(logic s, int a, output logic [7:0] d,
                         output logic den, output logic v);
    @(negedge clk);
    rd_req = 1; rd_sig = s; rd_addr = 13'(a);
    @(negedge clk);
    rd_req = 0; rd_sig = 0;
    d = rd_data; den = rd_denied; v = rd_valid;
  endtask

  task automatic t_reset();
    logic [7:0] d; logic den, v;
    chk(busy === 0 && fuse_ready === 0, "R1 busy/ready", {busy, fuse_ready}, 0);
    chk(rd_valid === 0 && rd_denied === 0, "R1 rd flags", {rd_valid, rd_denied}, 0);
    for (int k = 0; k < 8; k++) begin
      do_read(1, k, d, den, v);
      chk(v === 1 && d === 8'h00 && den === 0, "R1 sig byte zero", d, 0);
    end
  endtask

  // program one map; junk: drive fuse_valid in erase; poke: stray start mid-write
  task automatic t_program(logic full, logic lock, int seed, bit junk, bit poke);
    int cnt = 0, i = 0, c = 0, len;
    len = full ? FB + SB : FB;
    @(negedge clk);
    prog_start = 1; prog_full = full; prog_lock = lock;
    @(negedge clk);
    prog_start = 0; prog_full = 0; prog_lock = 0;
    chk(busy === 1, "R2 busy after start", busy, 1);
    while (fuse_ready !== 1 && cnt < 1000) begin
      cnt++;
      if (cnt == 6) chk(rd_valid === 0, "R10 read ignored while busy", rd_valid, 0);
      fuse_valid = junk; fuse_bit = 1;
      rd_req = (cnt == 5);
      @(negedge clk);
    end
    fuse_valid = 0; rd_req = 0;
    chk(cnt == EW, "R2 erase length", cnt, EW);
    while (i < len && c < 20000) begin
      c++;
      fuse_valid = !(c % 11 == 3);
      fuse_bit = pat(seed, i);
      prog_start = poke && (i == 1000) && fuse_valid;
      @(posedge clk);
      if (fuse_valid && fuse_ready) i++;
      @(negedge clk);
      if (prog_start) begin
        prog_start = 0;
        chk(fuse_ready === 1, "R10 stray start ignored", fuse_ready, 1);
      end
    end
    fuse_valid = 0;
    chk(busy === 0 && fuse_ready === 0, "R4 idle after last bit",
        {busy, fuse_ready}, 0);
  endtask

  task automatic t_verify(logic full, logic lock, int seed);
    logic [7:0] d, e; logic den, v;
    for (int a = 0; a < FB; a += 97) begin
      do_read(0, a, d, den, v);
      if (lock) chk(v && d === 8'h00 && den === 1, "R7 locked fuse read",
                    {den, d}, 9'h100);
      else chk(v && d === {7'b0, pat(seed, a)} && den === 0, "R6 fuse read",
               d, pat(seed, a));
    end
    do_read(0, FB - 1, d, den, v);
    chk(v && den === lock && d === (lock ? 8'h00 : {7'b0, pat(seed, FB - 1)}),
        "R3 last functional fuse", d, lock ? 0 : pat(seed, FB - 1));
    for (int b = 0; b < SB; b++) begin
      do_read(0, FB + b, d, den, v);
      e = {7'b0, full ? pat(seed, FB + b) : 1'b0};
      chk(v && d === e && den === 0, full ? "R8 sig bit read" : "R5 sig erased",
          d, e);
    end
    for (int k = 0; k < 8; k++) begin
      do_read(1, k, d, den, v);
      for (int j = 0; j < 8; j++) e[j] = full ? pat(seed, FB + 8 * k + j) : 1'b0;
      chk(v && d === e && den === 0, "R9 sig byte order", d, e);
    end
    do_read(0, FB + SB, d, den, v);
    chk(v && d === 8'h00 && den === 0, "R11 beyond map", {den, d}, 0);
    do_read(0, 8191, d, den, v);
    chk(v && d === 8'h00 && den === 0, "R11 top address", {den, d}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_program(1, 0, 1, 1, 0);   // R2 R3 long map, junk in erase
    t_verify(1, 0, 1);
    t_program(0, 0, 2, 0, 0);   // R5 short map clears old signature
    t_verify(0, 0, 2);
    t_program(1, 1, 3, 0, 1);   // R7 R8 R10 locked, stray start
    t_verify(1, 1, 3);
    t_program(0, 0, 4, 0, 0);   // R10 lock released by new program
    t_verify(0, 0, 4);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule